// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer with Slot Annulment

This block sequences the fetch program counter of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose instruction set has one architectural branch delay slot. Each cycle it picks the next fetch address. The default is the current address plus four. When a branch resolves in decode, the next address is the branch target if the branch is taken and the sequential address if it is not. The instruction that is in fetch while the branch resolves is the delay slot. It always moves on into decode, so the redirect costs no bubble.

Alongside the address, the block carries a valid bit and an annul bit for every stage. A cancelling branch that is not taken turns its slot instruction into a bubble after decode, so the slot has no architectural effect. Every other branch lets its slot complete normally. A stall freezes all of this state. A redirect that resolves during a stall is held and applied when the stall lifts. A branch found sitting in a delay slot is illegal: its redirect is dropped and an error flag is raised.

Top module: `dbr_fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_pc_o` becomes 0 and every bit of `valid_o` and `kill_o` becomes 0. Fetch validity (`valid_o[0]`) rises after the first edge with `rst_n` high, with `fetch_pc_o` still at 0.
- R2: Once fetch is valid, each unstalled edge with no applied redirect advances `fetch_pc_o` by 4.
- R3: A legal resolve moves the instruction in fetch into decode as the delay slot. It happens when `br_resolve_i` is high, decode is valid, and the decode instruction is not itself a delay slot. The next fetch address is `br_target_i` if `br_taken_i` is 1 and the current address plus 4 otherwise.
- R4: For a non-cancelling branch (`br_cancel_i`=0), the delay-slot instruction stays valid through decode, execute, memory and writeback, whether the branch is taken or not.
- R5: For a cancelling branch that is not taken, the slot shows `valid_o[1]`=1 with `kill_o[1]`=1 in decode. In each later stage it shows valid 0 with the kill bit 1. Bit positions are: 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback.
- R6: For a cancelling branch that is taken, the slot instruction stays valid through all stages and its kill bits stay 0.
- R7: An edge with `stall_i` high leaves `fetch_pc_o`, `valid_o` and `kill_o` unchanged.
- R8: A legal resolve seen while stalled is held and applied on the first unstalled edge. Resolve inputs presented while that redirect is held, including on the releasing edge, are ignored.
- R9: `br_resolve_i` has no effect when decode is invalid.
- R10: When `br_resolve_i` is high and decode holds a valid delay-slot instruction, `err_o` is 1 in that cycle and the redirect is ignored, so fetch continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze fetch address and pipeline state |
| br_resolve_i | input | 1 | Branch in decode resolves this cycle |
| br_taken_i | input | 1 | Resolved branch is taken |
| br_cancel_i | input | 1 | Resolved branch is a cancelling branch |
| br_target_i | input | PC_W | Resolved branch target address |
| fetch_pc_o | output | PC_W | Address of the instruction in fetch |
| valid_o | output | NSTAGE | Per-stage valid bit, bit 0 fetch through bit 4 writeback |
| kill_o | output | NSTAGE | Per-stage annul mark of a cancelled delay slot |
| err_o | output | 1 | Resolve attempted by a delay-slot instruction |

## Verification
The bench drives four branch kinds: ordinary taken, ordinary untaken, cancelling taken and cancelling untaken. Together they separate the one outcome that bubbles the slot from the three that keep it, and they show whether the redirect target or the sequential address follows the slot. Stalls are placed both around idle flow and across a resolve whose inputs change while held, which tells a latched redirect apart from a live or doubled one. Resolves are also placed on an empty decode stage and on a delay slot, which shows that the first is ignored and the second is flagged without moving fetch.

// File: rtl/dbr_pkg.sv
// Package: shared sizes and stage indices for the delayed-branch fetch sequencer.
// Assumes a five-stage in-order pipeline with branch resolution in decode.
package dbr_pkg;
    localparam int NSTAGE   = 5;
    localparam int PC_W     = 32;
    localparam int ST_IF    = 0;
    localparam int ST_ID    = 1;
    localparam int ST_EX    = 2;
    localparam int INSN_BYTES = 4;

    typedef struct packed {
        logic taken;
        logic cancel;
    } br_kind_t;
endpackage

// File: rtl/dbr_redir_hold.sv
// Module: holds a redirect that resolves during a stall and presents the
// redirect to apply on each unstalled edge.
// Assumes the caller only raises legal_i for a legal branch in decode.
module dbr_redir_hold
    import dbr_pkg::*;
#(
    parameter int PC_W_P = PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              legal_i,
    input  br_kind_t          kind_i,
    input  logic [PC_W_P-1:0] target_i,
    output logic              apply_o,
    output br_kind_t          kind_o,
    output logic [PC_W_P-1:0] target_o
);
    logic              held_q;
    br_kind_t          held_kind_q;
    logic [PC_W_P-1:0] held_tgt_q;

    // Select the held redirect over live inputs; apply only when unstalled.
    always_comb begin
        apply_o  = !stall_i && (held_q || legal_i);
        kind_o   = held_q ? held_kind_q : kind_i;
        target_o = held_q ? held_tgt_q  : target_i;
    end

    // Capture a legal resolve while stalled; release it on the first run edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q      <= 1'b0;
            held_kind_q <= '0;
            held_tgt_q  <= '0;
        end else if (!stall_i) begin
            held_q <= 1'b0;
        end else if (legal_i && !held_q) begin
            held_q      <= 1'b1;
            held_kind_q <= kind_i;
            held_tgt_q  <= target_i;
        end
    end

    // R8
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && stall_i) |=> (held_q && $stable(held_tgt_q) && $stable(held_kind_q)));
endmodule

// File: rtl/dbr_pc_gen.sv
// Module: fetch program counter register with sequential/target selection.
// Assumes apply_i is already qualified by stall; fetch starts after reset.
module dbr_pc_gen
    import dbr_pkg::*;
#(
    parameter int PC_W_P = PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              apply_i,
    input  logic              taken_i,
    input  logic [PC_W_P-1:0] target_i,
    output logic [PC_W_P-1:0] pc_o,
    output logic              started_o
);
    localparam logic [PC_W_P-1:0] STEP = PC_W_P'(INSN_BYTES);

    logic [PC_W_P-1:0] pc_q;
    logic [PC_W_P-1:0] pc_seq;
    logic [PC_W_P-1:0] pc_nxt;
    logic              started_q;

    // Sequential address is always formed; a taken redirect overrides it.
    always_comb begin
        pc_seq = pc_q + STEP;
        pc_nxt = (apply_i && taken_i) ? target_i : pc_seq;
    end

    // Hold address until fetch is started, then advance on each run edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            started_q <= 1'b0;
        end else if (!stall_i) begin
            started_q <= 1'b1;
            if (started_q) pc_q <= pc_nxt;
        end
    end

    assign pc_o      = pc_q;
    assign started_o = started_q;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !stall_i && !apply_i) |=> (pc_q == $past(pc_q) + STEP));
    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_q));
endmodule

// File: rtl/dbr_slot_track.sv
// Module: per-stage valid, delay-slot and annul marks shifted down the pipe.
// Assumes the instruction in fetch becomes the slot whenever a redirect applies.
module dbr_slot_track
    import dbr_pkg::*;
#(
    parameter int NST = NSTAGE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall_i,
    input  logic           fetch_vld_i,
    input  logic           apply_i,
    input  logic           annul_i,
    output logic [NST-1:0] vld_o,
    output logic [NST-1:0] slot_o,
    output logic [NST-1:0] ann_o
);
    logic [NST-1:0] vld_q;
    logic [NST-1:0] slot_q;
    logic [NST-1:0] ann_q;

    assign vld_q[ST_IF]  = fetch_vld_i;
    assign slot_q[ST_IF] = 1'b0;
    assign ann_q[ST_IF]  = 1'b0;

    // Decode entry: the fetched instruction becomes the slot on a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[ST_ID]  <= 1'b0;
            slot_q[ST_ID] <= 1'b0;
            ann_q[ST_ID]  <= 1'b0;
        end else if (!stall_i) begin
            vld_q[ST_ID]  <= fetch_vld_i;
            slot_q[ST_ID] <= fetch_vld_i && apply_i;
            ann_q[ST_ID]  <= fetch_vld_i && apply_i && annul_i;
        end
    end

    for (genvar s = ST_EX; s < NST; s++) begin : g_stage
        // Later stages: shift marks; an annulled instruction leaves as a bubble.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s]  <= 1'b0;
                slot_q[s] <= 1'b0;
                ann_q[s]  <= 1'b0;
            end else if (!stall_i) begin
                vld_q[s]  <= vld_q[s-1] && !ann_q[s-1];
                slot_q[s] <= slot_q[s-1];
                ann_q[s]  <= ann_q[s-1];
            end
        end
    end

    assign vld_o  = vld_q;
    assign slot_o = slot_q;
    assign ann_o  = ann_q;

    // R5
    annul_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[ST_ID] && ann_q[ST_ID] && !stall_i) |=> (!vld_q[ST_EX] && ann_q[ST_EX]));
    // R4
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[ST_ID] && slot_q[ST_ID] && !ann_q[ST_ID] && !stall_i) |=> vld_q[ST_EX]);
    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(vld_q[NST-1:ST_ID]) && $stable(ann_q[NST-1:ST_ID])));
endmodule

// File: rtl/dbr_fetch_seq.sv
// Module: top of the delayed-branch fetch sequencer. Qualifies branch resolves
// from decode, flags branches in delay slots, and ties together redirect hold,
// address generation and slot tracking.
// Assumes one delay slot, resolution in decode, synchronous active-low reset.
module dbr_fetch_seq
    import dbr_pkg::*;
#(
    parameter int PC_W_P = PC_W,
    parameter int NST    = NSTAGE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              br_resolve_i,
    input  logic              br_taken_i,
    input  logic              br_cancel_i,
    input  logic [PC_W_P-1:0] br_target_i,
    output logic [PC_W_P-1:0] fetch_pc_o,
    output logic [NST-1:0]    valid_o,
    output logic [NST-1:0]    kill_o,
    output logic              err_o
);
    logic              legal;
    logic              apply;
    br_kind_t          live_kind;
    br_kind_t          app_kind;
    logic [PC_W_P-1:0] app_tgt;
    logic              started;
    logic [NST-1:0]    vld;
    logic [NST-1:0]    slot;
    logic [NST-1:0]    ann;

    // Classify a resolve: legal from a normal decode instruction, error from a slot.
    always_comb begin
        legal            = br_resolve_i && vld[ST_ID] && !slot[ST_ID];
        err_o            = br_resolve_i && vld[ST_ID] && slot[ST_ID];
        live_kind.taken  = br_taken_i;
        live_kind.cancel = br_cancel_i;
    end

    dbr_redir_hold #(.PC_W_P(PC_W_P)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall_i  (stall_i),
        .legal_i  (legal),
        .kind_i   (live_kind),
        .target_i (br_target_i),
        .apply_o  (apply),
        .kind_o   (app_kind),
        .target_o (app_tgt)
    );

    dbr_pc_gen #(.PC_W_P(PC_W_P)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_i   (stall_i),
        .apply_i   (apply),
        .taken_i   (app_kind.taken),
        .target_i  (app_tgt),
        .pc_o      (fetch_pc_o),
        .started_o (started)
    );

    dbr_slot_track #(.NST(NST)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_i     (stall_i),
        .fetch_vld_i (started),
        .apply_i     (apply),
        .annul_i     (app_kind.cancel && !app_kind.taken),
        .vld_o       (vld),
        .slot_o      (slot),
        .ann_o       (ann)
    );

    assign valid_o = vld;
    assign kill_o  = ann;

    // R10
    slot_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !stall_i) |=> (fetch_pc_o == $past(fetch_pc_o) + PC_W_P'(INSN_BYTES)));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc_o == '0 && valid_o == '0 && kill_o == '0));
endmodule

// File: tb/test_dbr_fetch_seq.sv
module test_dbr_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        rslv = 1'b0;
    logic        tkn = 1'b0;
    logic        cncl = 1'b0;
    logic [31:0] tgt = '0;
    logic [31:0] pc;
    logic [4:0]  vo;
    logic [4:0]  ko;
    logic        eo;

    int nchk = 0;
    int nerr = 0;
    string cur = "R1";

    // behavioural reference: one record per pipeline position
    int  m_pc = 0;
    bit  m_run = 0;
    bit  m_v[5];
    bit  m_s[5];
    bit  m_k[5];
    bit  h_v = 0, h_t = 0, h_c = 0;
    int  h_tg = 0;

    always #4 clk = ~clk;

    dbr_fetch_seq i_dbr_fetch_seq (
        .clk(clk), .rst_n(rst_n), .stall_i(stall), .br_resolve_i(rslv),
        .br_taken_i(tkn), .br_cancel_i(cncl), .br_target_i(tgt),
        .fetch_pc_o(pc), .valid_o(vo), .kill_o(ko), .err_o(eo));

    task automatic chk(input string tag, input longint act, input longint exp, input string what);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit leg, app, t, c;
        int g;
        if (!rst_n) begin
            m_pc = 0; m_run = 0; h_v = 0;
            for (int i = 0; i < 5; i++) begin m_v[i] = 0; m_s[i] = 0; m_k[i] = 0; end
            return;
        end
        leg = rslv && m_v[1] && !m_s[1];
        if (stall) begin
            if (leg && !h_v) begin h_v = 1; h_t = tkn; h_c = cncl; h_tg = int'(tgt); end
            return;
        end
        app = h_v || leg;
        t = h_v ? h_t : tkn;
        c = h_v ? h_c : cncl;
        g = h_v ? h_tg : int'(tgt);
        h_v = 0;
        for (int i = 4; i >= 2; i--) begin
            m_v[i] = m_v[i-1] && !m_k[i-1];
            m_s[i] = m_s[i-1];
            m_k[i] = m_k[i-1];
        end
        m_v[1] = m_run;
        m_s[1] = m_run && app;
        m_k[1] = m_run && app && c && !t;
        if (m_run) m_pc = (app && t) ? g : m_pc + 4;
        m_run = 1;
        m_v[0] = 1;
    endtask

    task automatic step(input bit r, input bit st, input bit rs, input bit t,
                        input bit c, input int g);
        bit [4:0] ev, ek;
        @(negedge clk);
        rst_n = r; stall = st; rslv = rs; tkn = t; cncl = c; tgt = g;
        #1;
        for (int i = 0; i < 5; i++) begin ev[i] = m_v[i]; ek[i] = m_k[i]; end
        ev[0] = m_run;
        chk(cur, pc, m_pc, "fetch_pc");
        chk(cur, vo, ev, "valid");
        chk(cur, ko, ek, "kill");
        chk("R10", eo, rs && m_v[1] && m_s[1], "err");
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        cur = "R1";
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R9: resolve with decode empty right after reset
        cur = "R9";
        step(1, 0, 1, 1, 0, 32'h800);
        step(1, 0, 0, 0, 0, 0);
        cur = "R2";
        idle(4);
        // R3 R4: ordinary taken branch
        cur = "R3";
        step(1, 0, 1, 1, 0, 32'h100);
        cur = "R4";
        idle(6);
        // ordinary untaken
        step(1, 0, 1, 0, 0, 32'h300);
        idle(6);
        // R5: cancelling untaken
        cur = "R5";
        step(1, 0, 1, 0, 1, 32'h400);
        idle(6);
        // R6: cancelling taken
        cur = "R6";
        step(1, 0, 1, 1, 1, 32'h500);
        idle(6);
        // R7: stall with annul in flight
        cur = "R7";
        step(1, 0, 1, 0, 1, 32'h600);
        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        idle(5);
        // R8: resolve during stall, inputs change while held
        cur = "R8";
        step(1, 1, 1, 1, 0, 32'h700);
        step(1, 1, 1, 0, 1, 32'h9F0);
        step(1, 0, 1, 0, 0, 32'hAA0);
        idle(6);
        // R10: branch in delay slot
        cur = "R10";
        step(1, 0, 1, 1, 0, 32'hB00);
        step(1, 0, 1, 1, 0, 32'hC00);
        idle(6);
        // reset again mid-flow
        cur = "R1";
        step(1, 0, 1, 0, 1, 32'hD00);
        step(0, 0, 0, 0, 0, 0);
        idle(3);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule